// File: doc/BRIEF.md
# Multifunction Pin Function Router

This block connects eight general-purpose digital pins, M0 to M7, to a chip's internal functions. Software gives each pin an 8-bit configuration value. The top bit of that value sets the pin's direction. In monitor mode the pin drives one internal status line out of the chip. In control mode the pin's input drives one internal control line. The seven low bits choose which line. A global enable word must hold 0x01, or no pin does anything.

All register writes go into a shadow copy. They take effect together on an `io_update` strobe, which copies the shadow into the active set. Control inputs pass through a two-flop synchronizer before they reach the internal control lines. Several control-mode pins may select the same control line; the lowest-numbered pin then drives it. One control code is the output-sync function. If it is assigned while the pins are off, turning the pins on emits a single sync pulse.

Top module: `mfpin_router`

## Requirements
- R1: Register writes address the shadow set. Address 0 is the enable word. Address k+1 is the configuration of pin Mk, for k = 0 to 7. Writes to addresses 9 to 15 change nothing.
- R2: Pins act only while the active enable word equals 0x01. With any other value, `pin_oe`, `pin_out` and `ctrl_out` are all 0; the one exception is the pulse of R9.
- R3: A pin whose active configuration has bit 7 = 1 is in monitor mode. It drives `pin_oe` = 1 and sets `pin_out` to `stat_in[code]`, where code is bits 6:0. A code of 8 or more drives 0.
- R4: A pin whose configuration has bit 7 = 0 is in control mode. It keeps `pin_oe` and `pin_out` at 0, and its synchronized input drives `ctrl_out[code]`. Codes of 8 or more reach no control line. The inputs of monitor-mode pins reach no control line.
- R5: When several enabled control-mode pins select one control line, only the lowest-numbered of them drives it.
- R6: The active set changes only at the rising edge where `io_update` is 1. Between updates, shadow writes have no effect on the outputs.
- R7: A change on `pin_in` reaches `ctrl_out` after exactly two rising edges.
- R8: A control line that no enabled control-mode pin selects stays at 0.
- R9: Consider an update that moves the active enable word from any other value to 0x01 while a shadow control-mode pin selects code 5, the sync control. That update sets `ctrl_out[5]` to 1 for exactly the one cycle after the edge. No other update does this.
- R10: After reset, every shadow and active register is 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Shadow register write strobe |
| cfg_addr | input | 4 | Shadow register address |
| cfg_wdata | input | 8 | Shadow register write data |
| io_update | input | 1 | Copies shadow registers to the active set |
| pin_in | input | 8 | Pad input values of M0..M7 |
| stat_in | input | 8 | Internal status lines available to monitor pins |
| pin_out | output | 8 | Pad output values of M0..M7 |
| pin_oe | output | 8 | Pad output enables of M0..M7 |
| ctrl_out | output | 8 | Internal control lines driven by control pins |

## Verification
The bench sets up two collisions on one control line. A router without lowest-index priority would let M2 or M5 override M1 or M3, and `ctrl_out` would follow the wrong pin. It uses out-of-range codes in both directions and writes to unmapped addresses. A decoder that wraps codes or addresses would drive a line or a pin that should stay quiet. It uses an enable value other than 0x01, and it repeats an update after the pins are on. A design that tests only bit 0 of the enable word, or that pulses sync on every update, would drive outputs or emit a pulse where none is due. It also times the synchronizer edge by edge, to catch a path that is one flop short or one flop long.

// File: rtl/mfpin_router.sv
module mfpin_router #(
  parameter int NUM_PINS  = 8,
  parameter int NUM_CTRL  = 8,
  parameter int NUM_STAT  = 8,
  parameter int CFG_W     = 8,
  parameter int SYNC_CODE = 5,
  parameter logic [CFG_W-1:0] EN_KEY = CFG_W'(1),
  localparam int CODE_W = CFG_W - 1,
  localparam int ADDR_W = $clog2(NUM_PINS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                io_update,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_STAT-1:0] stat_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_CTRL-1:0] ctrl_out
);

  logic [CFG_W-1:0]    sh_en, act_en;
  logic [CFG_W-1:0]    sh_cfg  [NUM_PINS];
  logic [CFG_W-1:0]    act_cfg [NUM_PINS];
  logic [NUM_PINS-1:0] sync1, sync2;
  logic [NUM_CTRL-1:0] routed;
  logic                sync_auto, sh_has_sync;

  wire pins_on = (act_en == EN_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en  <= '0;
      act_en <= '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        sh_cfg[i]  <= '0;
        act_cfg[i] <= '0;
      end
    end else begin
      if (cfg_wr) begin
        if (cfg_addr == '0) sh_en <= cfg_wdata;
        for (int i = 0; i < NUM_PINS; i++)
          if (cfg_addr == ADDR_W'(i + 1)) sh_cfg[i] <= cfg_wdata;
      end
      if (io_update) begin
        act_en <= sh_en;
        for (int i = 0; i < NUM_PINS; i++) act_cfg[i] <= sh_cfg[i];
      end
    end
  end

  always_comb begin
    sh_has_sync = 1'b0;
    for (int i = 0; i < NUM_PINS; i++)
      if (!sh_cfg[i][CFG_W-1] && sh_cfg[i][CODE_W-1:0] == CODE_W'(SYNC_CODE))
        sh_has_sync = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      sync_auto <= 1'b0;
    end else begin
      sync1     <= pin_in;
      sync2     <= sync1;
      sync_auto <= io_update && (act_en != EN_KEY) && (sh_en == EN_KEY) && sh_has_sync;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      pin_oe[i]  = pins_on && act_cfg[i][CFG_W-1];
      pin_out[i] = 1'b0;
      for (int s = 0; s < NUM_STAT; s++)
        if (pin_oe[i] && act_cfg[i][CODE_W-1:0] == CODE_W'(s))
          pin_out[i] = stat_in[s];
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CTRL; c++) begin
      routed[c] = 1'b0;
      for (int i = NUM_PINS - 1; i >= 0; i--)
        if (pins_on && !act_cfg[i][CFG_W-1] && act_cfg[i][CODE_W-1:0] == CODE_W'(c))
          routed[c] = sync2[i];
    end
  end

  always_comb begin
    ctrl_out = routed;
    if (SYNC_CODE < NUM_CTRL) ctrl_out[SYNC_CODE] = routed[SYNC_CODE] | sync_auto;
  end

endmodule

module mfpin_router_chk #(
  parameter int NUM_PINS = 8,
  parameter int NUM_CTRL = 8,
  parameter int CFG_W    = 8,
  parameter logic [CFG_W-1:0] EN_KEY = CFG_W'(1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_update,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_CTRL-1:0] ctrl_out,
  input logic [CFG_W-1:0]    act_en,
  input logic                sync_auto
);
  a_r2_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en != EN_KEY && !sync_auto) |-> (pin_oe == '0 && pin_out == '0 && ctrl_out == '0));
  a_r4_out_only_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  a_r6_held_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    !io_update |=> ($stable(pin_oe) && $stable(act_en)));
  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_auto |=> !sync_auto);
  a_r9_pulse_from_update: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_auto) |-> $past(io_update));
endmodule

bind mfpin_router mfpin_router_chk #(
  .NUM_PINS(NUM_PINS), .NUM_CTRL(NUM_CTRL), .CFG_W(CFG_W), .EN_KEY(EN_KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_update(io_update), .pin_out(pin_out),
  .pin_oe(pin_oe), .ctrl_out(ctrl_out), .act_en(act_en), .sync_auto(sync_auto)
);

// File: tb/mfpin_router_tb_top.sv
`timescale 1ns/1ps
module mfpin_router_tb_top;
  logic       clk = 0, rst_n = 0, cfg_wr = 0, io_update = 0;
  logic [3:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0, pin_in = 0, stat_in = 0;
  logic [7:0] pin_out, pin_oe, ctrl_out;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  mfpin_router dut_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .io_update(io_update), .pin_in(pin_in), .stat_in(stat_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ctrl_out(ctrl_out));

  // {pin_in, stat_in, expected ctrl_out, expected pin_out}
  localparam logic [31:0] VEC [8] = '{
    {8'h00, 8'h00, 8'h00, 8'h00},
    {8'h02, 8'h08, 8'h04, 8'h01},
    {8'h04, 8'h01, 8'h00, 8'h10},
    {8'h08, 8'h09, 8'h80, 8'h11},
    {8'h20, 8'hF6, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 8'h84, 8'h11},
    {8'h40, 8'h00, 8'h00, 8'h00},
    {8'h0A, 8'h08, 8'h84, 8'h01}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic upd();
    @(negedge clk); io_update = 1;
    @(negedge clk); io_update = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset pin_oe", pin_oe, 8'h00);
    check("R10 reset pin_out", pin_out, 8'h00);
    check("R10 reset ctrl_out", ctrl_out, 8'h00);
    rst_n = 1;

    wr(1, 8'h83); wr(2, 8'h02); wr(3, 8'h02); wr(4, 8'h07);
    wr(5, 8'h80); wr(6, 8'h07); wr(7, 8'h64); wr(8, 8'hF8);
    wr(0, 8'h01);
    settle();
    check("R6 no update no effect", pin_oe, 8'h00);
    upd();
    check("R6 update applies oe", pin_oe, 8'h91);

    wr(9, 8'h00); wr(15, 8'h00);
    upd();
    check("R1 unmapped address ignored", pin_oe, 8'h91);

    for (int v = 0; v < 8; v++) begin
      pin_in = VEC[v][31:24]; stat_in = VEC[v][23:16];
      settle();
      check($sformatf("R4 R5 R8 vec%0d ctrl", v), ctrl_out, VEC[v][15:8]);
      check($sformatf("R3 vec%0d pin_out", v), pin_out, VEC[v][7:0]);
    end

    pin_in = 0; settle();
    @(negedge clk); pin_in = 8'h02;
    @(negedge clk); check("R7 one edge not yet", ctrl_out, 8'h00);
    @(negedge clk); check("R7 two edges", ctrl_out, 8'h04);

    wr(0, 8'h03); upd();
    pin_in = 8'hFF; stat_in = 8'hFF; settle();
    check("R2 bad key oe", pin_oe, 8'h00);
    check("R2 bad key pin_out", pin_out, 8'h00);
    check("R2 bad key ctrl", ctrl_out, 8'h00);

    pin_in = 0; stat_in = 0;
    wr(7, 8'h05); wr(0, 8'h01); settle();
    upd();
    check("R9 sync pulse on enable", ctrl_out, 8'h20);
    @(negedge clk);
    check("R9 pulse one cycle", ctrl_out, 8'h00);
    check("R9 oe back on", pin_oe, 8'h91);
    upd();
    check("R9 no pulse when already on", ctrl_out, 8'h00);
    @(negedge clk);
    check("R9 no pulse later", ctrl_out, 8'h00);
    pin_in = 8'h40; settle();
    check("R4 sync via pin", ctrl_out, 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule